// File: doc/BRIEF.md
# Crossbar Spiking Neuron Core

A small time-stepped array of integrate-and-fire neurons with a linear leak. Binary axon lines reach the neurons through a programmable one-bit connectivity matrix. Each axon carries a two-bit type code. For every connected and active axon, each neuron picks one of its three signed weights by that type code and adds it to its membrane potential. Once all axons have been seen, a per-neuron signed leak is added. A neuron whose potential is then strictly above its threshold emits a spike and restarts from zero.

The default core has 16 axons and 8 neurons. The lower 8 axons come from the external spike vector. Axon 8+i carries the spike of neuron i from the previous time step, which gives recurrent connections. Software loads the matrix, the types, the weights, the leaks and the thresholds through a write port while the core is idle. A slow tick strobe then starts each time step. The core scans one axon per clock, publishes the new spike vector atomically at the end of the step and pulses a done flag.

Top module: `spike_xbar_core`

## Requirements
- R1: After reset, spk_o, busy_o and done_o are 0, every potential is 0 and every configuration field is 0, so a tick with all external axons active produces no spike.
- R2: A tick_i pulse sampled while busy_o is 0 starts a time step and busy_o is 1 from the next cycle. A tick_i pulse while busy_o is 1 is ignored and starts no second step.
- R3: Axons are scanned one per clock. done_o is 1 for exactly one cycle, N_AXON+1 clock edges after the edge that accepts the tick, and busy_o falls at that same edge.
- R4: Axon j < N_EXT (N_EXT = N_AXON-N_NEUR) takes ext_spk_i[j] and axon N_EXT+i takes spk_o[i], both sampled at the accepting edge. Later changes of ext_spk_i during the step have no effect.
- R5: Kind 0 writes the connectivity row of axon cfg_addr_i from cfg_data_i[N_NEUR-1:0]. Bit i set makes neuron i integrate that axon, and bit i clear makes neuron i ignore it.
- R6: Kind 1 writes the type of axon cfg_addr_i from cfg_data_i[1:0]. Types 0, 1 and 2 select the matching weight. Type 3 adds nothing.
- R7: Kind 2 writes the weight at cfg_addr_i = 4*neuron + type from cfg_data_i[8:0] as a signed value. An address whose low two bits are 3 is ignored.
- R8: Kind 3 writes the leak of neuron cfg_addr_i from cfg_data_i[8:0] as a signed value. The leak is added once per step, after all axon contributions.
- R9: Kind 4 writes the threshold of neuron cfg_addr_i from cfg_data_i[15:0] as a signed value. A neuron spikes only if its post-leak potential is strictly greater than the threshold, and it then resets to 0. Otherwise it keeps the post-leak value.
- R10: Each addition to the 16-bit signed potential saturates to the range -32768..32767 instead of wrapping.
- R11: spk_o changes only at the edge that raises done_o and holds its value for the whole next step.
- R12: Configuration writes presented while busy_o is 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 3 | Field selector: 0 row, 1 type, 2 weight, 3 leak, 4 threshold |
| cfg_addr_i | input | 5 | Axon index, neuron index, or 4*neuron+type |
| cfg_data_i | input | 16 | Write data |
| tick_i | input | 1 | Time-step start strobe |
| ext_spk_i | input | 8 | External axon activity |
| busy_o | output | 1 | Time step in progress |
| done_o | output | 1 | One-cycle end-of-step pulse |
| spk_o | output | 8 | Neuron spikes of the last completed step |

## Verification
The assertions check on every cycle that done_o is a single-cycle pulse that comes exactly N_AXON+1 edges after acceptance and together with the fall of busy_o. They also check that spk_o moves only on done_o, that the configuration stays frozen while busy, and that after each step every neuron either spiked with a zero potential or stays at or below its threshold. Only the directed scenarios can show the arithmetic itself: weight selection by type, gating by the matrix, leak ordering, saturation at both rails and the one-step delay of looped-back spikes. They also show that the external vector and a second tick are ignored once a step has begun.

// File: rtl/spk_pkg.sv
package spk_pkg;
  typedef enum logic [2:0] {
    CFG_XBAR = 3'd0,
    CFG_TYPE = 3'd1,
    CFG_WGT  = 3'd2,
    CFG_LEAK = 3'd3,
    CFG_THR  = 3'd4
  } cfg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } seq_st_e;

  localparam int unsigned N_TYPES = 3;
endpackage

// File: rtl/spk_cfg_store.sv
module spk_cfg_store
  import spk_pkg::*;
#(
  parameter int unsigned N_AXON = 16,
  parameter int unsigned N_NEUR = 8,
  parameter int unsigned VW     = 16,
  parameter int unsigned WW     = 9,
  parameter int unsigned AW     = 5
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     we_i,
  input  logic [2:0]                               kind_i,
  input  logic [AW-1:0]                            addr_i,
  input  logic [VW-1:0]                            data_i,
  output logic [N_AXON-1:0][N_NEUR-1:0]            xbar_o,
  output logic [N_AXON-1:0][1:0]                   atype_o,
  output logic [N_NEUR-1:0][N_TYPES-1:0][WW-1:0]   wgt_o,
  output logic [N_NEUR-1:0][WW-1:0]                leak_o,
  output logic [N_NEUR-1:0][VW-1:0]                thr_o
);

  for (genvar j = 0; j < N_AXON; j++) begin : g_ax
    logic [N_NEUR-1:0] row_q;
    logic [1:0]        typ_q;
    logic              hit;
    assign hit = we_i && (addr_i == AW'(j));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q <= '0;
        typ_q <= '0;
      end else if (hit) begin
        if (kind_i == CFG_XBAR) row_q <= data_i[N_NEUR-1:0];
        if (kind_i == CFG_TYPE) typ_q <= data_i[1:0];
      end
    end
    assign xbar_o[j]  = row_q;
    assign atype_o[j] = typ_q;
  end

  for (genvar i = 0; i < N_NEUR; i++) begin : g_nr
    logic [WW-1:0] leak_q;
    logic [VW-1:0] thr_q;
    logic          hit;
    assign hit = we_i && (addr_i == AW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        leak_q <= '0;
        thr_q  <= '0;
      end else if (hit) begin
        if (kind_i == CFG_LEAK) leak_q <= data_i[WW-1:0];
        if (kind_i == CFG_THR)  thr_q  <= data_i;
      end
    end
    assign leak_o[i] = leak_q;
    assign thr_o[i]  = thr_q;

    for (genvar k = 0; k < N_TYPES; k++) begin : g_w
      logic [WW-1:0] w_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) w_q <= '0;
        else if (we_i && kind_i == CFG_WGT && addr_i == AW'(i * 4 + k))
          w_q <= data_i[WW-1:0];
      end
      assign wgt_o[i][k] = w_q;
    end
  end

endmodule

// File: rtl/spk_seq.sv
module spk_seq
  import spk_pkg::*;
#(
  parameter int unsigned N_AXON = 16,
  parameter int unsigned AXW    = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  output logic           accept_o,
  output logic           scan_o,
  output logic           fin_o,
  output logic [AXW-1:0] idx_o,
  output logic           busy_o,
  output logic           done_o
);

  seq_st_e        st_q;
  logic [AXW-1:0] idx_q;
  logic           done_q;

  assign accept_o = tick_i && (st_q == ST_IDLE);
  assign scan_o   = (st_q == ST_SCAN);
  assign fin_o    = (st_q == ST_FIN);
  assign busy_o   = (st_q != ST_IDLE);
  assign idx_o    = idx_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st_q == ST_FIN);
      unique case (st_q)
        ST_IDLE: if (tick_i) begin
          st_q  <= ST_SCAN;
          idx_q <= '0;
        end
        ST_SCAN: begin
          if (idx_q == AXW'(N_AXON - 1)) st_q <= ST_FIN;
          else idx_q <= idx_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spk_neuron.sv
module spk_neuron
  import spk_pkg::*;
#(
  parameter int unsigned VW = 16,
  parameter int unsigned WW = 9
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             add_en_i,
  input  logic [1:0]                       type_i,
  input  logic [N_TYPES-1:0][WW-1:0]       wgt_i,
  input  logic signed [WW-1:0]             leak_i,
  input  logic signed [VW-1:0]             thr_i,
  input  logic                             fin_i,
  output logic [VW-1:0]                    v_o,
  output logic                             spk_o
);

  function automatic logic signed [VW-1:0] sat_add(input logic signed [VW-1:0] a,
                                                    input logic signed [WW-1:0] b);
    logic [VW:0] s;
    s = {a[VW-1], a} + {{(VW + 1 - WW){b[WW-1]}}, b};
    if (s[VW] != s[VW-1])
      return s[VW] ? {1'b1, {(VW - 1){1'b0}}} : {1'b0, {(VW - 1){1'b1}}};
    return s[VW-1:0];
  endfunction

  logic signed [VW-1:0] v_q, v_leak;
  logic signed [WW-1:0] w_sel;
  logic                 spk_q;

  always_comb begin
    case (type_i)
      2'd0:    w_sel = wgt_i[0];
      2'd1:    w_sel = wgt_i[1];
      2'd2:    w_sel = wgt_i[2];
      default: w_sel = '0;
    endcase
    v_leak = sat_add(v_q, leak_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= '0;
      spk_q <= 1'b0;
    end else if (add_en_i) begin
      v_q <= sat_add(v_q, w_sel);
    end else if (fin_i) begin
      if (v_leak > thr_i) begin
        v_q   <= '0;
        spk_q <= 1'b1;
      end else begin
        v_q   <= v_leak;
        spk_q <= 1'b0;
      end
    end
  end

  assign v_o   = v_q;
  assign spk_o = spk_q;

endmodule

// File: rtl/spike_xbar_core.sv
module spike_xbar_core
  import spk_pkg::*;
#(
  parameter int unsigned N_AXON = 16,
  parameter int unsigned N_NEUR = 8,
  parameter int unsigned VW     = 16,
  parameter int unsigned WW     = 9,
  localparam int unsigned N_EXT = N_AXON - N_NEUR,
  localparam int unsigned AXW   = $clog2(N_AXON),
  localparam int unsigned NW    = $clog2(N_NEUR),
  localparam int unsigned AW    = (AXW > NW + 2) ? AXW : NW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_kind_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [VW-1:0]     cfg_data_i,
  input  logic              tick_i,
  input  logic [N_EXT-1:0]  ext_spk_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [N_NEUR-1:0] spk_o
);

  logic [N_AXON-1:0][N_NEUR-1:0]          xbar_w;
  logic [N_AXON-1:0][1:0]                 atype_w;
  logic [N_NEUR-1:0][N_TYPES-1:0][WW-1:0] wgt_w;
  logic [N_NEUR-1:0][WW-1:0]              leak_w;
  logic [N_NEUR-1:0][VW-1:0]              thr_w;
  logic [N_NEUR-1:0][VW-1:0]              v_all;

  logic           accept, scan, fin;
  logic [AXW-1:0] idx;
  logic [N_AXON-1:0] act_q;
  logic              cur_act;
  logic [N_NEUR-1:0] cur_row;
  logic [1:0]        cur_type;

  spk_cfg_store #(
    .N_AXON(N_AXON), .N_NEUR(N_NEUR), .VW(VW), .WW(WW), .AW(AW)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && !busy_o),
    .kind_i  (cfg_kind_i),
    .addr_i  (cfg_addr_i),
    .data_i  (cfg_data_i),
    .xbar_o  (xbar_w),
    .atype_o (atype_w),
    .wgt_o   (wgt_w),
    .leak_o  (leak_w),
    .thr_o   (thr_w)
  );

  spk_seq #(.N_AXON(N_AXON), .AXW(AXW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .accept_o (accept),
    .scan_o   (scan),
    .fin_o    (fin),
    .idx_o    (idx),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  // snapshot of axon activity: external lines low, looped-back spikes high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else if (accept) act_q <= {spk_o, ext_spk_i};
  end

  assign cur_act  = act_q[idx];
  assign cur_row  = xbar_w[idx];
  assign cur_type = atype_w[idx];

  for (genvar i = 0; i < N_NEUR; i++) begin : g_neur
    logic spk_n;
    spk_neuron #(.VW(VW), .WW(WW)) u_nrn (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .add_en_i (scan && cur_act && cur_row[i]),
      .type_i   (cur_type),
      .wgt_i    (wgt_w[i]),
      .leak_i   (leak_w[i]),
      .thr_i    (thr_w[i]),
      .fin_i    (fin),
      .v_o      (v_all[i]),
      .spk_o    (spk_n)
    );
    assign spk_o[i] = spk_n;
  end

endmodule

// File: rtl/spk_core_chk.sv
module spk_core_chk
  import spk_pkg::*;
#(
  parameter int unsigned N_AXON = 16,
  parameter int unsigned N_NEUR = 8,
  parameter int unsigned VW     = 16,
  parameter int unsigned WW     = 9
) (
  input logic                                   clk_i,
  input logic                                   rst_ni,
  input logic                                   tick_i,
  input logic                                   busy_o,
  input logic                                   done_o,
  input logic [N_NEUR-1:0]                      spk_o,
  input logic [N_NEUR-1:0][VW-1:0]              v_i,
  input logic [N_NEUR-1:0][VW-1:0]              thr_i,
  input logic [N_NEUR-1:0][WW-1:0]              leak_i,
  input logic [N_NEUR-1:0][N_TYPES-1:0][WW-1:0] wgt_i,
  input logic [N_AXON-1:0][N_NEUR-1:0]          xbar_i,
  input logic [N_AXON-1:0][1:0]                 atype_i
);
  localparam int unsigned CW = $clog2(N_AXON + 4);

  logic [CW-1:0]     busy_cnt;
  logic [N_NEUR-1:0] ok_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= '0;
    else busy_cnt <= busy_o ? busy_cnt + 1'b1 : '0;
  end

  always_comb begin
    for (int i = 0; i < N_NEUR; i++)
      ok_vec[i] = spk_o[i] ? (v_i[i] == '0) : ($signed(v_i[i]) <= $signed(thr_i[i]));
  end

  // R2
  busy_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !busy_o) |=> busy_o);

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R3
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_cnt == CW'(N_AXON + 1)));

  // R11
  spk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(spk_o));

  // R12
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(thr_i) && $stable(leak_i) && $stable(wgt_i)
                && $stable(xbar_i) && $stable(atype_i)));

  // R9
  fire_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (&ok_vec));

endmodule

bind spike_xbar_core spk_core_chk #(
  .N_AXON(N_AXON), .N_NEUR(N_NEUR), .VW(VW), .WW(WW)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .spk_o   (spk_o),
  .v_i     (v_all),
  .thr_i   (thr_w),
  .leak_i  (leak_w),
  .wgt_i   (wgt_w),
  .xbar_i  (xbar_w),
  .atype_i (atype_w)
);

// File: tb/spike_xbar_core_tb_top.sv
`timescale 1ns/1ps
module spike_xbar_core_tb_top;
  localparam int NA = 16;
  localparam int NN = 8;
  localparam int NE = NA - NN;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_kind_i = '0;
  logic [4:0]  cfg_addr_i = '0;
  logic [15:0] cfg_data_i = '0;
  logic        tick_i = 1'b0;
  logic [NE-1:0] ext_spk_i = '0;
  logic        busy_o, done_o;
  logic [NN-1:0] spk_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  spike_xbar_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_kind_i(cfg_kind_i),
    .cfg_addr_i(cfg_addr_i), .cfg_data_i(cfg_data_i), .tick_i(tick_i),
    .ext_spk_i(ext_spk_i), .busy_o(busy_o), .done_o(done_o), .spk_o(spk_o)
  );

  // reference model state
  bit [NN-1:0] m_xb [NA];
  int          m_ty [NA];
  int          m_w  [NN][3];
  int          m_lk [NN];
  int          m_th [NN];
  int          m_v  [NN];
  bit [NN-1:0] m_spk;

  function automatic int sat16(int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    tick_i = 1'b0;
    cfg_we_i = 1'b0;
    ext_spk_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int j = 0; j < NA; j++) begin m_xb[j] = '0; m_ty[j] = 0; end
    for (int i = 0; i < NN; i++) begin
      m_lk[i] = 0; m_th[i] = 0; m_v[i] = 0;
      for (int k = 0; k < 3; k++) m_w[i][k] = 0;
    end
    m_spk = '0;
  endtask

  task automatic raw_wr(int kind, int addr, int val);
    @(negedge clk_i);
    cfg_we_i = 1'b1;
    cfg_kind_i = 3'(kind);
    cfg_addr_i = 5'(addr);
    cfg_data_i = 16'(val);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic cfg_wr(int kind, int addr, int val);
    raw_wr(kind, addr, val);
    case (kind)
      0: m_xb[addr] = NN'(val);
      1: m_ty[addr] = val & 3;
      2: if ((addr & 3) != 3) m_w[addr >> 2][addr & 3] = int'($signed(9'(val)));
      3: m_lk[addr] = int'($signed(9'(val)));
      4: m_th[addr] = int'($signed(16'(val)));
      default: ;
    endcase
  endtask

  task automatic model_tick(bit [NE-1:0] ext);
    bit [NA-1:0] act;
    act = {m_spk, ext};
    for (int j = 0; j < NA; j++)
      if (act[j] && m_ty[j] != 3)
        for (int i = 0; i < NN; i++)
          if (m_xb[j][i]) m_v[i] = sat16(m_v[i] + m_w[i][m_ty[j]]);
    for (int i = 0; i < NN; i++) begin
      int t;
      t = sat16(m_v[i] + m_lk[i]);
      if (t > m_th[i]) begin m_spk[i] = 1'b1; m_v[i] = 0; end
      else begin m_spk[i] = 1'b0; m_v[i] = t; end
    end
  endtask

  // one time step; disturb drives a second tick, a config write and new ext bits mid-scan
  task automatic run_tick(bit [NE-1:0] ext, string tag, bit disturb = 0);
    int cnt;
    bit [NN-1:0] prev;
    prev = spk_o;
    model_tick(ext);
    @(negedge clk_i);
    ext_spk_i = ext;
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    cnt = 1;
    chk(busy_o === 1'b1, "R2 busy after tick", int'(busy_o), 1);
    while (done_o !== 1'b1 && cnt < 100) begin
      if (cnt == 3 && disturb) begin
        tick_i = 1'b1;
        ext_spk_i = ~ext;
        cfg_we_i = 1'b1;
        cfg_kind_i = 3'd4;
        cfg_addr_i = 5'd0;
        cfg_data_i = 16'h8000;
      end else begin
        tick_i = 1'b0;
        cfg_we_i = 1'b0;
      end
      if (cnt == 5) chk(spk_o === prev, "R11 spikes held during scan", int'(spk_o), int'(prev));
      @(negedge clk_i);
      cnt++;
    end
    tick_i = 1'b0;
    cfg_we_i = 1'b0;
    chk(cnt == NA + 2, "R3 done latency", cnt, NA + 2);
    chk(spk_o === m_spk, tag, int'(spk_o), int'(m_spk));
    @(negedge clk_i);
    chk(done_o === 1'b0 && busy_o === 1'b0, "R3 done single pulse", int'(done_o), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(spk_o === '0 && busy_o === 1'b0 && done_o === 1'b0, "R1 reset outputs",
        int'({busy_o, done_o, spk_o}), 0);
    run_tick('1, "R1 cleared config gives no spike");
  endtask

  task automatic t_integrate();
    do_reset();
    cfg_wr(0, 0, 8'h01);
    cfg_wr(2, 0, 5);
    cfg_wr(4, 0, 10);
    cfg_wr(1, 1, 0);
    cfg_wr(2, 4 * 1, 100);
    run_tick(8'h01, "R5 first integrate");
    run_tick(8'h03, "R9 equal to threshold no spike, R5 clear bit ignored");
    run_tick(8'h01, "R9 above threshold spikes");
    run_tick(8'h02, "R5 unconnected axon only");
  endtask

  task automatic t_types();
    do_reset();
    for (int j = 0; j < 4; j++) begin
      cfg_wr(0, j, 8'h02);
      cfg_wr(1, j, j);
    end
    cfg_wr(2, 4 + 0, 7);
    cfg_wr(2, 4 + 1, 20);
    cfg_wr(2, 4 + 2, -9);
    cfg_wr(2, 4 + 3, 200);
    cfg_wr(4, 1, 15);
    run_tick(8'h04, "R6 type 2 inhibitory");
    run_tick(8'h02, "R6 type 1 below threshold");
    run_tick(8'h02, "R7 type 1 crosses threshold");
    for (int r = 0; r < 3; r++) run_tick(8'h08, "R6 type 3 adds nothing R7");
    run_tick(8'h07, "R6 mixed types");
  endtask

  task automatic t_leak();
    do_reset();
    cfg_wr(3, 2, 4);
    cfg_wr(4, 2, 10);
    cfg_wr(0, 5, 8'h08);
    cfg_wr(2, 4 * 3, 6);
    cfg_wr(3, 3, -3);
    cfg_wr(4, 3, 8);
    for (int r = 0; r < 4; r++) run_tick(8'h20, "R8 leak per step");
  endtask

  task automatic t_sat();
    do_reset();
    for (int j = 0; j < NE; j++) cfg_wr(0, j, 8'h03);
    cfg_wr(2, 0, 255);
    cfg_wr(4, 0, 32766);
    cfg_wr(2, 4, -256);
    for (int r = 0; r < 19; r++) run_tick(8'hFF, "R10 saturation both rails");
  endtask

  task automatic t_loop();
    do_reset();
    cfg_wr(0, 0, 8'h01);
    cfg_wr(2, 0, 50);
    cfg_wr(4, 0, 10);
    cfg_wr(0, NE + 0, 8'h10);
    cfg_wr(1, NE + 0, 2);
    cfg_wr(2, 4 * 4 + 2, 100);
    cfg_wr(4, 4, 50);
    run_tick(8'h01, "R4 source spikes");
    run_tick(8'h00, "R4 looped spike reaches target next step");
    run_tick(8'h00, "R4 loop quiet");
  endtask

  task automatic t_busy();
    do_reset();
    cfg_wr(0, 0, 8'h01);
    cfg_wr(2, 0, 6);
    cfg_wr(4, 0, 10);
    run_tick(8'h01, "R12 write during step ignored R4 ext sampled", 1'b1);
    begin
      bit extra;
      extra = 0;
      for (int c = 0; c < 24; c++) begin
        @(negedge clk_i);
        if (done_o === 1'b1 || busy_o === 1'b1) extra = 1;
      end
      chk(!extra, "R2 tick while busy ignored", int'(extra), 0);
    end
    run_tick(8'h01, "R12 old threshold still applies");
  endtask

  initial begin
    t_reset();
    t_integrate();
    t_types();
    t_leak();
    t_sat();
    t_loop();
    t_busy();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule